// File: doc/BRIEF.md
# Gate Drive Timing Sequencer

This block turns the PWM commands of a three-phase half-bridge into gate-current control signals. Each phase has a high-side and a low-side switch, and each switch runs its own small state machine. When a switch's command changes, that switch drives gate current for a programmable number of clock cycles and then drops into a hold state. Turning the switch on uses a source-current enable. Turning it off uses a sink-current enable.

The gate command outputs follow the PWM inputs combinationally, so the drive window never adds delay to the switching edges. A new command that arrives during a window cuts that window short. Whenever one switch of a phase is in its turn-on window, a strong pulldown is enabled on the other switch's gate.

The block also presents the current-setting code that applies to each switch. There are separate source and sink codes, one pair for all high sides and one pair for all low sides. Codes are clamped to the valid range of twelve levels. If both switches of a phase are commanded on at once, both gates are forced off and a sticky per-phase error flag is raised.

Top module: `gdt_sequencer`

## Requirements
- R1: `gate_hi[p]` equals `pwm_hi[p] & ~pwm_lo[p]` and `gate_lo[p]` equals `pwm_lo[p] & ~pwm_hi[p]` in the same cycle, with no register in the path.
- R2: When a switch's effective command rises (0 to 1, including the first 1 after reset), its source enable is asserted from the next cycle for the full window length. After the window it is deasserted and the switch holds on.
- R3: When a switch's effective command falls, its sink enable is asserted from the next cycle for the full window length. This is subject to R6. After the window it is deasserted and the switch holds off.
- R4: The window length is `WIN_BASE << win_sel` clock cycles (4, 8, 16 or 32 for `win_sel` 0 to 3 at default). `win_sel` is sampled at the command edge that starts the window.
- R5: A command edge that arrives during an active window ends that window at once. The window for the new direction then starts with its full length.
- R6: While one switch of a phase is in its turn-on window, the pulldown enable of the other switch in that phase is asserted. The pulldown overrides that switch's sink enable.
- R7: For every switch, at most one of source enable, sink enable and pulldown enable is asserted in any cycle.
- R8: The current code output of a switch shows its side's source code while the source enable is set. It shows its side's sink code while the sink enable is set, and 0 otherwise. High sides use `hs_*` codes and low sides use `ls_*` codes. Each code is 4 bits, packed with phase p in bits `[4p+3:4p]`.
- R9: A code value of 12 to 15 appears on the current code output as 11.
- R10: If both PWM inputs of a phase are high, the block treats both switches as commanded off. `st_err[p]` is then set in the following cycle and stays set until reset.
- R11: While reset is high and in the first cycle after it, with PWM inputs low, every enable, current code and error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | NPH | High-side PWM command per phase |
| pwm_lo | input | NPH | Low-side PWM command per phase |
| hs_src_code | input | CW | Turn-on current code shared by high sides |
| hs_snk_code | input | CW | Turn-off current code shared by high sides |
| ls_src_code | input | CW | Turn-on current code shared by low sides |
| ls_snk_code | input | CW | Turn-off current code shared by low sides |
| win_sel | input | 2 | Drive window length select |
| gate_hi | output | NPH | High-side gate command |
| gate_lo | output | NPH | Low-side gate command |
| hi_src_en | output | NPH | High-side source current enable |
| hi_snk_en | output | NPH | High-side sink current enable |
| hi_pd_en | output | NPH | High-side strong pulldown enable |
| lo_src_en | output | NPH | Low-side source current enable |
| lo_snk_en | output | NPH | Low-side sink current enable |
| lo_pd_en | output | NPH | Low-side strong pulldown enable |
| hi_cur | output | NPH*CW | Active current code per high side |
| lo_cur | output | NPH*CW | Active current code per low side |
| st_err | output | NPH | Sticky shoot-through error per phase |

## Verification
The first stimulus is complementary PWM with long periods at each window select. This shows whether windows run to their exact length and whether the opposing pulldown replaces the sink enable. The second is pulses shorter than the window, which separates a correctly cut-short window from one that runs on or is not restarted. The third is overlapping high-side and low-side commands, which exercises gate masking and the sticky error flag through a reset. A long random run with changing codes, including the out-of-range values 12 to 15, covers code selection and clamping under every state combination.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

    typedef enum logic [2:0] {
        SW_IDLE_OFF  = 3'd0,
        SW_DRIVE_ON  = 3'd1,
        SW_HOLD_ON   = 3'd2,
        SW_DRIVE_OFF = 3'd3,
        SW_HOLD_OFF  = 3'd4
    } sw_state_e;

    typedef struct packed {
        logic src;
        logic snk;
        logic pd;
    } sw_en_t;

    // Number of cycles a drive window lasts for a given select.
    function automatic int unsigned drive_cycles(input int unsigned base, input logic [1:0] sel);
        return base << sel;
    endfunction

    // Limit a current code to the highest valid level.
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned levels);
        return (code >= levels) ? (levels - 1) : code;
    endfunction

endpackage

// File: rtl/gdt_switch_fsm.sv
module gdt_switch_fsm
    import gdt_pkg::*;
#(
    parameter int unsigned WIN_BASE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd,
    input  logic [1:0] win_sel,
    output sw_state_e  state
);
    localparam int unsigned CNT_W = $clog2(WIN_BASE * 8);

    logic             cmd_q;
    logic [CNT_W-1:0] cnt;
    logic             edge_seen;
    logic [CNT_W-1:0] load_val;

    assign edge_seen = (cmd != cmd_q);
    assign load_val  = CNT_W'(drive_cycles(WIN_BASE, win_sel) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_IDLE_OFF;
            cmd_q <= 1'b0;
            cnt   <= '0;
        end else begin
            cmd_q <= cmd;
            if (edge_seen) begin
                state <= cmd ? SW_DRIVE_ON : SW_DRIVE_OFF;
                cnt   <= load_val;
            end else begin
                unique case (state)
                    SW_DRIVE_ON: begin
                        if (cnt == '0) state <= SW_HOLD_ON;
                        else           cnt   <= cnt - 1'b1;
                    end
                    SW_DRIVE_OFF: begin
                        if (cnt == '0) state <= SW_HOLD_OFF;
                        else           cnt   <= cnt - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    rise_starts_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmd) && !$past(rst)) |=> (state == SW_DRIVE_ON));

    // R3
    fall_starts_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmd) && !$past(rst)) |=> (state == SW_DRIVE_OFF));

    // R2
    hold_on_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SW_HOLD_ON) |-> cmd_q);

endmodule

// File: rtl/gdt_phase.sv
module gdt_phase
    import gdt_pkg::*;
#(
    parameter int unsigned WIN_BASE = 4,
    parameter int unsigned CW       = 4,
    parameter int unsigned LEVELS   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwm_hi,
    input  logic          pwm_lo,
    input  logic [CW-1:0] hs_src_code,
    input  logic [CW-1:0] hs_snk_code,
    input  logic [CW-1:0] ls_src_code,
    input  logic [CW-1:0] ls_snk_code,
    input  logic [1:0]    win_sel,
    output logic          gate_hi,
    output logic          gate_lo,
    output sw_en_t        en_hi,
    output sw_en_t        en_lo,
    output logic [CW-1:0] cur_hi,
    output logic [CW-1:0] cur_lo,
    output logic          st_err
);
    logic          both_on;
    logic          eff   [2];
    sw_state_e     st    [2];
    sw_en_t        en    [2];
    logic [CW-1:0] src_c [2];
    logic [CW-1:0] snk_c [2];
    logic [CW-1:0] cur   [2];
    logic          err_q;

    assign both_on  = pwm_hi & pwm_lo;
    assign eff[0]   = pwm_hi & ~both_on;
    assign eff[1]   = pwm_lo & ~both_on;
    assign src_c[0] = hs_src_code;
    assign snk_c[0] = hs_snk_code;
    assign src_c[1] = ls_src_code;
    assign snk_c[1] = ls_snk_code;

    for (genvar s = 0; s < 2; s++) begin : g_side
        gdt_switch_fsm #(.WIN_BASE(WIN_BASE)) u_fsm (
            .clk     (clk),
            .rst     (rst),
            .cmd     (eff[s]),
            .win_sel (win_sel),
            .state   (st[s])
        );

        always_comb begin
            en[s].pd  = (st[1-s] == SW_DRIVE_ON);
            en[s].src = (st[s] == SW_DRIVE_ON);
            en[s].snk = (st[s] == SW_DRIVE_OFF) && !en[s].pd;
            if (en[s].src)      cur[s] = CW'(clamp_code(int'(src_c[s]), LEVELS));
            else if (en[s].snk) cur[s] = CW'(clamp_code(int'(snk_c[s]), LEVELS));
            else                cur[s] = '0;
        end

        // R7
        one_enable_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({en[s].src, en[s].snk, en[s].pd}));

        // R9
        code_range_chk: assert property (@(posedge clk) disable iff (rst)
            cur[s] <= CW'(LEVELS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (both_on) err_q <= 1'b1;
    end

    assign gate_hi = eff[0];
    assign gate_lo = eff[1];
    assign en_hi   = en[0];
    assign en_lo   = en[1];
    assign cur_hi  = cur[0];
    assign cur_lo  = cur[1];
    assign st_err  = err_q;

    // R10
    no_dual_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_err |=> st_err);

endmodule

// File: rtl/gdt_sequencer.sv
module gdt_sequencer
    import gdt_pkg::*;
#(
    parameter int unsigned NPH      = 3,
    parameter int unsigned CW       = 4,
    parameter int unsigned LEVELS   = 12,
    parameter int unsigned WIN_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPH-1:0]    pwm_hi,
    input  logic [NPH-1:0]    pwm_lo,
    input  logic [CW-1:0]     hs_src_code,
    input  logic [CW-1:0]     hs_snk_code,
    input  logic [CW-1:0]     ls_src_code,
    input  logic [CW-1:0]     ls_snk_code,
    input  logic [1:0]        win_sel,
    output logic [NPH-1:0]    gate_hi,
    output logic [NPH-1:0]    gate_lo,
    output logic [NPH-1:0]    hi_src_en,
    output logic [NPH-1:0]    hi_snk_en,
    output logic [NPH-1:0]    hi_pd_en,
    output logic [NPH-1:0]    lo_src_en,
    output logic [NPH-1:0]    lo_snk_en,
    output logic [NPH-1:0]    lo_pd_en,
    output logic [NPH*CW-1:0] hi_cur,
    output logic [NPH*CW-1:0] lo_cur,
    output logic [NPH-1:0]    st_err
);
    for (genvar p = 0; p < NPH; p++) begin : g_ph
        sw_en_t en_hi;
        sw_en_t en_lo;

        gdt_phase #(
            .WIN_BASE (WIN_BASE),
            .CW       (CW),
            .LEVELS   (LEVELS)
        ) u_ph (
            .clk         (clk),
            .rst         (rst),
            .pwm_hi      (pwm_hi[p]),
            .pwm_lo      (pwm_lo[p]),
            .hs_src_code (hs_src_code),
            .hs_snk_code (hs_snk_code),
            .ls_src_code (ls_src_code),
            .ls_snk_code (ls_snk_code),
            .win_sel     (win_sel),
            .gate_hi     (gate_hi[p]),
            .gate_lo     (gate_lo[p]),
            .en_hi       (en_hi),
            .en_lo       (en_lo),
            .cur_hi      (hi_cur[p*CW +: CW]),
            .cur_lo      (lo_cur[p*CW +: CW]),
            .st_err      (st_err[p])
        );

        assign hi_src_en[p] = en_hi.src;
        assign hi_snk_en[p] = en_hi.snk;
        assign hi_pd_en[p]  = en_hi.pd;
        assign lo_src_en[p] = en_lo.src;
        assign lo_snk_en[p] = en_lo.snk;
        assign lo_pd_en[p]  = en_lo.pd;
    end

endmodule

// File: tb/gdt_sequencer_tb.sv
`timescale 1ns/1ps
module gdt_sequencer_tb;
    localparam int NPH = 3, CW = 4, LEVELS = 12, WIN_BASE = 4;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic [NPH-1:0]    pwm_hi, pwm_lo;
    logic [CW-1:0]     hs_src_code, hs_snk_code, ls_src_code, ls_snk_code;
    logic [1:0]        win_sel;
    logic [NPH-1:0]    gate_hi, gate_lo, hi_src_en, hi_snk_en, hi_pd_en;
    logic [NPH-1:0]    lo_src_en, lo_snk_en, lo_pd_en, st_err;
    logic [NPH*CW-1:0] hi_cur, lo_cur;

    gdt_sequencer #(.NPH(NPH), .CW(CW), .LEVELS(LEVELS), .WIN_BASE(WIN_BASE)) u_dut (
        .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .hs_src_code(hs_src_code), .hs_snk_code(hs_snk_code),
        .ls_src_code(ls_src_code), .ls_snk_code(ls_snk_code), .win_sel(win_sel),
        .gate_hi(gate_hi), .gate_lo(gate_lo),
        .hi_src_en(hi_src_en), .hi_snk_en(hi_snk_en), .hi_pd_en(hi_pd_en),
        .lo_src_en(lo_src_en), .lo_snk_en(lo_snk_en), .lo_pd_en(lo_pd_en),
        .hi_cur(hi_cur), .lo_cur(lo_cur), .st_err(st_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model: 0 idle-off, 1 turning on, 2 on, 3 turning off, 4 off
    int m_st   [NPH][2];
    int m_cnt  [NPH][2];
    bit m_prev [NPH][2];
    bit m_err  [NPH];

    function automatic int clampc(input int c);
        return (c > LEVELS - 1) ? LEVELS - 1 : c;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NPH; p++) begin
            m_err[p] = 0;
            for (int s = 0; s < 2; s++) begin
                m_st[p][s] = 0; m_cnt[p][s] = 0; m_prev[p][s] = 0;
            end
        end
    endtask

    task automatic model_adv();
        for (int p = 0; p < NPH; p++) begin
            bit both;
            bit e [2];
            both = pwm_hi[p] && pwm_lo[p];
            e[0] = pwm_hi[p] && !both;
            e[1] = pwm_lo[p] && !both;
            if (both) m_err[p] = 1;
            for (int s = 0; s < 2; s++) begin
                if (e[s] != m_prev[p][s]) begin
                    m_st[p][s]  = e[s] ? 1 : 3;
                    m_cnt[p][s] = (WIN_BASE << win_sel) - 1;
                end else if (m_st[p][s] == 1 || m_st[p][s] == 3) begin
                    if (m_cnt[p][s] == 0) m_st[p][s] = m_st[p][s] + 1;
                    else                  m_cnt[p][s] = m_cnt[p][s] - 1;
                end
                m_prev[p][s] = e[s];
            end
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NPH; p++) begin
            bit both;
            both = pwm_hi[p] && pwm_lo[p];
            chk("R1/R10", "gate_hi", int'(gate_hi[p]), int'(pwm_hi[p] && !both));
            chk("R1/R10", "gate_lo", int'(gate_lo[p]), int'(pwm_lo[p] && !both));
            chk("R10", "st_err", int'(st_err[p]), int'(m_err[p]));
            for (int s = 0; s < 2; s++) begin
                int pd, src, snk, cur, a_src, a_snk, a_pd, a_cur, sc, kc;
                pd  = (m_st[p][1-s] == 1);
                src = (m_st[p][s] == 1);
                snk = (m_st[p][s] == 3) && !pd;
                sc  = (s == 0) ? int'(hs_src_code) : int'(ls_src_code);
                kc  = (s == 0) ? int'(hs_snk_code) : int'(ls_snk_code);
                cur = src ? clampc(sc) : (snk ? clampc(kc) : 0);
                a_src = (s == 0) ? int'(hi_src_en[p]) : int'(lo_src_en[p]);
                a_snk = (s == 0) ? int'(hi_snk_en[p]) : int'(lo_snk_en[p]);
                a_pd  = (s == 0) ? int'(hi_pd_en[p])  : int'(lo_pd_en[p]);
                a_cur = (s == 0) ? int'(hi_cur[p*CW +: CW]) : int'(lo_cur[p*CW +: CW]);
                chk("R2/R4/R5", "src_en", a_src, src);
                chk("R3/R4/R5", "snk_en", a_snk, snk);
                chk("R6", "pd_en", a_pd, pd);
                chk("R7", "enable count<=1", int'((a_src + a_snk + a_pd) <= 1), 1);
                chk("R8/R9", "cur_code", a_cur, cur);
            end
        end
    endtask

    task automatic step(input logic [NPH-1:0] hi, input logic [NPH-1:0] lo);
        pwm_hi = hi;
        pwm_lo = lo;
        model_adv();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic hold(input logic [NPH-1:0] hi, input logic [NPH-1:0] lo, input int n);
        for (int i = 0; i < n; i++) step(hi, lo);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwm_hi = '0;
        pwm_lo = '0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R11: outputs cleared while reset is still high
        chk("R11", "enables in reset",
            int'({hi_src_en, hi_snk_en, hi_pd_en, lo_src_en, lo_snk_en, lo_pd_en} != 0), 0);
        chk("R11", "err in reset", int'(st_err), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R11: outputs still clear one cycle after reset
        chk("R11", "cur after reset", int'({hi_cur, lo_cur} != 0), 0);
        chk("R11", "err after reset", int'(st_err), 0);
        model_adv();
        compare_all();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        hs_src_code = 4'd5;  hs_snk_code = 4'd9;
        ls_src_code = 4'd3;  ls_snk_code = 4'd14;
        win_sel = 2'd0;
        do_reset();

        // R2/R3/R4/R6: complementary switching at every window length
        for (int w = 0; w < 4; w++) begin
            win_sel = 2'(w);
            hold(3'b001, 3'b110, 40);
            hold(3'b110, 3'b001, 40);
            hold(3'b000, 3'b000, 40);
        end

        // R5: pulses shorter than the window
        win_sel = 2'd3;
        for (int k = 1; k < 6; k++) begin
            hold(3'b010, 3'b000, k);
            hold(3'b000, 3'b010, k);
        end
        hold(3'b000, 3'b000, 40);

        // R9: out-of-range codes on both sides
        hs_src_code = 4'd15; hs_snk_code = 4'd12;
        ls_src_code = 4'd11; ls_snk_code = 4'd13;
        win_sel = 2'd1;
        hold(3'b111, 3'b000, 12);
        hold(3'b000, 3'b111, 12);

        // R10: overlap on phase 2, then reset clears the flag
        hold(3'b100, 3'b100, 3);
        hold(3'b000, 3'b100, 12);
        hold(3'b000, 3'b000, 12);
        do_reset();

        // Random run
        begin
            logic [NPH-1:0] rh, rl;
            rh = '0; rl = '0;
            for (int i = 0; i < 3000; i++) begin
                for (int p = 0; p < NPH; p++) begin
                    int r;
                    r = $urandom_range(0, 99);
                    if (r < 4)       rh[p] = ~rh[p];
                    else if (r < 8)  rl[p] = ~rl[p];
                    else if (r == 8) begin rh[p] = 1'b1; rl[p] = 1'b1; end
                end
                if (i % 50 == 0) win_sel = 2'($urandom_range(0, 3));
                if (i % 97 == 0) begin
                    hs_src_code = 4'($urandom_range(0, 15));
                    hs_snk_code = 4'($urandom_range(0, 15));
                    ls_src_code = 4'($urandom_range(0, 15));
                    ls_snk_code = 4'($urandom_range(0, 15));
                end
                step(rh, rl);
                if (i % 1000 == 999) begin
                    do_reset();
                    rh = '0; rl = '0;
                end
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule